// File: doc/BRIEF.md
# Box-Muller Gaussian Noise Generator

This block turns two streams of uniform integers into pairs of standard-normal samples in fixed point, one pair on every cycle that the caller enables. Each uniform stream comes from its own combined three-word Tausworthe generator. The first stream (u0) sets the radius sqrt(-2·ln(u0)), the second (u1) sets the angle 2π·u1, and the block returns the radius times the sine and times the cosine of that angle on two separate ports. All three nonlinear functions are piecewise-linear: a 64-entry table of offsets and per-segment rises is indexed by the top bits of the uniform, and one multiply-add interpolates inside the segment.

The two outputs are meant to drive two independent random processes, for instance a price path and its volatility. Generator state comes from parameters at reset and can be rewritten one 32-bit word at a time through a seed port. The pipeline is fully fed: a new pair enters on every enabled cycle, and each result appears a fixed number of cycles later with its valid flag.

Top module: `box_muller_gen`

## Requirements
- R1: While reset is asserted and after it is released, x1_valid and x2_valid are 0 and x1 and x2 are 0; after reset, generator A holds legalised SEED_A and generator B holds legalised SEED_B, with word k in bits [32k+31:32k].
- R2: An accepted cycle advances every word of each generator once: word0 b=((s<<13)^s)>>19, s=((s&0xFFFFFFFE)<<12)^b; word1 b=((s<<2)^s)>>25, s=((s&0xFFFFFFF8)<<4)^b; word2 b=((s<<3)^s)>>11, s=((s&0xFFFFFFF0)<<17)^b. The generator output is the XOR of the three updated words. Generators hold their state on cycles without an accepted sample.
- R3: u0 is bits [31:8] of generator A's output and u1 is bits [31:8] of generator B's output, each read as an unsigned fraction of 2^24.
- R4: x1 = f(u0)·sin(2π·u1) and x2 = f(u0)·cos(2π·u1) with f(u) = sqrt(-2·ln u), each 24-bit two's complement with 20 fractional bits, computed through 64-segment tables selected by the top 6 bits of the uniform; whenever u0 is at least 2^18 codes, each output lies within 0.06 of the exact value.
- R5: A u0 code of 0 is processed as code 1, so the radius sqrt(x1²+x2²) is within 0.03 of sqrt(48·ln 2) ≈ 5.768.
- R6: x1_valid and x2_valid rise exactly 4 cycles after an accepted sample, one result per accepted cycle in order, with no result for any cycle that was not accepted.
- R7: A cycle with seed_load high writes seed_value into word seed_word (0, 1 or 2) of generator A when seed_gen is 0 or of generator B when seed_gen is 1; the next accepted sample steps from that state. seed_word 3 writes nothing.
- R8: A seed word below its minimum (2 for word0, 8 for word1, 16 for word2) is stored ORed with that minimum; this applies to reset seeds and loaded seeds.
- R9: in_enable is ignored on a cycle with seed_load high: no result is produced for it and neither generator advances.
- R10: Over 4096 consecutive samples, each output has mean within ±0.1 and variance in [0.85, 1.15], and the sample correlation of x1 and x2 is below 0.08 in magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_enable | input | 1 | Request one sample pair this cycle |
| seed_load | input | 1 | Write one generator word this cycle |
| seed_gen | input | 1 | Generator select: 0 = A (radius), 1 = B (angle) |
| seed_word | input | 2 | Word index within the generator |
| seed_value | input | 32 | Seed word value |
| x1 | output | OUT_W (24) | Sine-branch sample, 20 fractional bits |
| x1_valid | output | 1 | x1 holds a new sample |
| x2 | output | OUT_W (24) | Cosine-branch sample, 20 fractional bits |
| x2_valid | output | 1 | x2 holds a new sample |

## Verification
The bench keeps the default widths (24-bit uniforms, 6 segment bits, 20 and 22 fractional bits) and overrides SEED_A and SEED_B with its own words, one of them below its minimum so that legalisation at reset shows in the very first samples. Known seeds let a bench-side generator model predict every uniform exactly, so each output is compared against the exact trigonometric value, and a word for generator A can be solved so that the next u0 is exactly zero. Long back-to-back runs bring the distribution and cross-correlation tests within reach, while gapped bursts and loads issued together with an enable expose state holding and the blocked-sample path.

// File: rtl/bmg_pkg.sv
package bmg_pkg;

    localparam int TAUS_W  = 32;
    localparam int N_WORDS = 3;

    localparam int FN_MAG = 0;
    localparam int FN_SIN = 1;
    localparam int FN_COS = 2;

    // Smallest legal value of each generator word.
    function automatic logic [TAUS_W-1:0] word_floor(input int c);
        case (c)
            0:       return 32'd2;
            1:       return 32'd8;
            default: return 32'd16;
        endcase
    endfunction

    function automatic logic [TAUS_W-1:0] word_legal(input int c, input logic [TAUS_W-1:0] v);
        return (v < word_floor(c)) ? (v | word_floor(c)) : v;
    endfunction

    // One step of a single component recurrence.
    function automatic logic [TAUS_W-1:0] word_step(input int c, input logic [TAUS_W-1:0] s);
        logic [TAUS_W-1:0] fb;
        case (c)
            0: begin
                fb = ((s << 13) ^ s) >> 19;
                return ((s & 32'hFFFF_FFFE) << 12) ^ fb;
            end
            1: begin
                fb = ((s << 2) ^ s) >> 25;
                return ((s & 32'hFFFF_FFF8) << 4) ^ fb;
            end
            default: begin
                fb = ((s << 3) ^ s) >> 11;
                return ((s & 32'hFFFF_FFF0) << 17) ^ fb;
            end
        endcase
    endfunction

endpackage

// File: rtl/bmg_taus.sv
module bmg_taus
    import bmg_pkg::*;
#(
    parameter logic [95:0] SEED = 96'h0000_0100_0000_0200_0000_0400,
    parameter int          RW   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                load,
    input  logic [1:0]          load_idx,
    input  logic [TAUS_W-1:0]   load_val,
    output logic [RW-1:0]       rnd
);

    logic [TAUS_W-1:0] nx [N_WORDS];

    for (genvar c = 0; c < N_WORDS; c++) begin : g_word
        localparam int LIVE_SH = (c == 0) ? 1 : ((c == 1) ? 3 : 4);
        logic [TAUS_W-1:0] st_q;

        assign nx[c] = word_step(c, st_q);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= word_legal(c, SEED[TAUS_W*c +: TAUS_W]);
            end else if (load && (load_idx == 2'(c))) begin
                st_q <= word_legal(c, load_val);
            end else if (step) begin
                st_q <= nx[c];
            end
        end

        // R2: the bits that feed the recurrence never collapse to zero
        a_r2_word_live: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q >> LIVE_SH) != '0);

        // R8: a loaded word is never below its floor
        a_r8_load_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (load && (load_idx == 2'(c))) |=> (st_q >= word_floor(c)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd <= '0;
        end else if (step) begin
            rnd <= RW'((nx[0] ^ nx[1] ^ nx[2]) >> (TAUS_W - RW));
        end
    end

endmodule

// File: rtl/bmg_pwl.sv
module bmg_pwl
    import bmg_pkg::*;
#(
    parameter int FUNC     = FN_MAG,
    parameter int U_W      = 24,
    parameter int SEG_BITS = 6,
    parameter int VAL_W    = 25,
    parameter int FRAC_OUT = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [U_W-1:0]          u,
    output logic signed [VAL_W-1:0] y
);

    localparam int  SEGS   = 1 << SEG_BITS;
    localparam int  FR_W   = U_W - SEG_BITS;
    localparam int  ACC_W  = VAL_W + FR_W + 1;
    localparam real SCALE  = 2.0 ** FRAC_OUT;
    localparam real TWO_PI = 6.283185307179586;

    logic signed [VAL_W-1:0] base_tbl [SEGS];
    logic signed [VAL_W-1:0] rise_tbl [SEGS];

    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        localparam real XA  = real'(k) / real'(SEGS);
        localparam real XAM = (k == 0) ? (1.0 / (2.0 ** U_W)) : XA;
        localparam real XB  = real'(k + 1) / real'(SEGS);
        localparam real VA  = (FUNC == FN_MAG) ? $sqrt(-2.0 * $ln(XAM)) :
                              (FUNC == FN_SIN) ? $sin(TWO_PI * XA) : $cos(TWO_PI * XA);
        localparam real VB  = (FUNC == FN_MAG) ? $sqrt(-2.0 * $ln(XB)) :
                              (FUNC == FN_SIN) ? $sin(TWO_PI * XB) : $cos(TWO_PI * XB);
        localparam int  IA  = $rtoi(VA * SCALE + ((VA < 0.0) ? -0.5 : 0.5));
        localparam int  IB  = $rtoi(VB * SCALE + ((VB < 0.0) ? -0.5 : 0.5));
        assign base_tbl[k] = VAL_W'(IA);
        assign rise_tbl[k] = VAL_W'(IB - IA);
    end

    // Stage 1: segment lookup
    logic signed [VAL_W-1:0] base_q;
    logic signed [VAL_W-1:0] rise_q;
    logic [FR_W-1:0]         pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            rise_q <= '0;
            pos_q  <= '0;
        end else begin
            base_q <= base_tbl[u[U_W-1 -: SEG_BITS]];
            rise_q <= rise_tbl[u[U_W-1 -: SEG_BITS]];
            pos_q  <= u[FR_W-1:0];
        end
    end

    // Stage 2: one multiply-add inside the segment
    logic signed [ACC_W-1:0] acc;
    assign acc = (ACC_W'(base_q) <<< FR_W) + (rise_q * $signed({1'b0, pos_q}));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y <= '0;
        end else begin
            y <= VAL_W'(acc >>> FR_W);
        end
    end

endmodule

// File: rtl/box_muller_gen.sv
module box_muller_gen
    import bmg_pkg::*;
#(
    parameter int          U_W       = 24,
    parameter int          SEG_BITS  = 6,
    parameter int          MAG_FRAC  = 20,
    parameter int          TRIG_FRAC = 22,
    parameter int          OUT_W     = 24,
    parameter logic [95:0] SEED_A    = {32'h8F4C_2A17, 32'h1B87_3593, 32'h5BD1_E995},
    parameter logic [95:0] SEED_B    = {32'hC2B2_AE35, 32'h27D4_EB2F, 32'h1656_67B1}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_enable,
    input  logic             seed_load,
    input  logic             seed_gen,
    input  logic [1:0]       seed_word,
    input  logic [31:0]      seed_value,
    output logic [OUT_W-1:0] x1,
    output logic             x1_valid,
    output logic [OUT_W-1:0] x2,
    output logic             x2_valid
);

    localparam int VAL_W    = ((MAG_FRAC + 4 > TRIG_FRAC + 2) ? MAG_FRAC + 4 : TRIG_FRAC + 2) + 1;
    localparam int PROD_W   = 2 * VAL_W;
    localparam int TAUS_LAT = 1;
    localparam int PWL_LAT  = 2;
    localparam int MUL_LAT  = 1;
    localparam int LAT      = TAUS_LAT + PWL_LAT + MUL_LAT;

    logic accept;
    assign accept = in_enable && !seed_load;

    logic [U_W-1:0] u0_raw;
    logic [U_W-1:0] u1_raw;
    logic [U_W-1:0] u0_safe;

    bmg_taus #(.SEED(SEED_A), .RW(U_W)) u_gen_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (accept),
        .load     (seed_load && !seed_gen),
        .load_idx (seed_word),
        .load_val (seed_value),
        .rnd      (u0_raw)
    );

    bmg_taus #(.SEED(SEED_B), .RW(U_W)) u_gen_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (accept),
        .load     (seed_load && seed_gen),
        .load_idx (seed_word),
        .load_val (seed_value),
        .rnd      (u1_raw)
    );

    // Zero would send the logarithm to infinity: use the smallest code instead.
    assign u0_safe = (u0_raw == '0) ? U_W'(1) : u0_raw;

    logic signed [VAL_W-1:0] mag_v;
    logic signed [VAL_W-1:0] sin_v;
    logic signed [VAL_W-1:0] cos_v;

    bmg_pwl #(.FUNC(FN_MAG), .U_W(U_W), .SEG_BITS(SEG_BITS), .VAL_W(VAL_W), .FRAC_OUT(MAG_FRAC)) u_mag (
        .clk (clk), .rst_n (rst_n), .u (u0_safe), .y (mag_v)
    );

    bmg_pwl #(.FUNC(FN_SIN), .U_W(U_W), .SEG_BITS(SEG_BITS), .VAL_W(VAL_W), .FRAC_OUT(TRIG_FRAC)) u_sin (
        .clk (clk), .rst_n (rst_n), .u (u1_raw), .y (sin_v)
    );

    bmg_pwl #(.FUNC(FN_COS), .U_W(U_W), .SEG_BITS(SEG_BITS), .VAL_W(VAL_W), .FRAC_OUT(TRIG_FRAC)) u_cos (
        .clk (clk), .rst_n (rst_n), .u (u1_raw), .y (cos_v)
    );

    logic signed [PROD_W-1:0] p_sin;
    logic signed [PROD_W-1:0] p_cos;
    assign p_sin = mag_v * sin_v;
    assign p_cos = mag_v * cos_v;

    logic [LAT-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1    <= '0;
            x2    <= '0;
            vld_q <= '0;
        end else begin
            x1    <= OUT_W'(p_sin >>> TRIG_FRAC);
            x2    <= OUT_W'(p_cos >>> TRIG_FRAC);
            vld_q <= {vld_q[LAT-2:0], accept};
        end
    end

    assign x1_valid = vld_q[LAT-1];
    assign x2_valid = vld_q[LAT-1];

    // R6: an accepted request yields a result after the fixed latency
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##LAT x1_valid);

    // R9: a cycle spent loading a seed never produces a result
    a_r9_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |-> ##LAT !x1_valid);

    // R4: the radius table output is never negative
    a_r4_mag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        mag_v >= 0);

    // R4: interpolated sine and cosine stay within one
    a_r4_trig_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_v <= (VAL_W'(1) <<< TRIG_FRAC)) && (sin_v >= -(VAL_W'(1) <<< TRIG_FRAC)) &&
        (cos_v <= (VAL_W'(1) <<< TRIG_FRAC)) && (cos_v >= -(VAL_W'(1) <<< TRIG_FRAC)));

endmodule

// File: tb/box_muller_gen_bench.sv
module box_muller_gen_bench;

    localparam logic [95:0] B_SEED_A = {32'h7A3C_91E5, 32'h0F1E_2D3C, 32'hA5A5_1234};
    localparam logic [95:0] B_SEED_B = {32'h3141_5926, 32'h0000_0003, 32'hDEAD_BEEF};
    localparam int  LATENCY = 4;
    localparam real OSCALE  = 1048576.0;
    localparam real USCALE  = 16777216.0;
    localparam real TWO_PI  = 6.283185307179586;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_enable = 0;
    logic        seed_load = 0;
    logic        seed_gen = 0;
    logic [1:0]  seed_word = 0;
    logic [31:0] seed_value = 0;
    logic [23:0] x1;
    logic [23:0] x2;
    logic        x1_valid;
    logic        x2_valid;

    box_muller_gen #(.SEED_A(B_SEED_A), .SEED_B(B_SEED_B)) u_box_muller_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_enable  (in_enable),
        .seed_load  (seed_load),
        .seed_gen   (seed_gen),
        .seed_word  (seed_word),
        .seed_value (seed_value),
        .x1         (x1),
        .x1_valid   (x1_valid),
        .x2         (x2),
        .x2_valid   (x2_valid)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int extra = 0;
    bit stats_on = 0;
    int n_stat = 0;
    real s1 = 0.0, s2 = 0.0, q1 = 0.0, q2 = 0.0, c12 = 0.0;

    logic [31:0] ga [3];
    logic [31:0] gb [3];

    logic [23:0] q_u0 [$];
    logic [23:0] q_u1 [$];
    int          q_cyc [$];
    string       q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] floor_of(input int c);
        return (c == 0) ? 32'd2 : ((c == 1) ? 32'd8 : 32'd16);
    endfunction

    function automatic logic [31:0] legal(input int c, input logic [31:0] v);
        return (v < floor_of(c)) ? (v | floor_of(c)) : v;
    endfunction

    function automatic logic [31:0] nxt(input int c, input logic [31:0] s);
        logic [31:0] t;
        if (c == 0) begin
            t = ((s << 13) ^ s) >> 19;
            return ((s & 32'hFFFF_FFFE) << 12) ^ t;
        end else if (c == 1) begin
            t = ((s << 2) ^ s) >> 25;
            return ((s & 32'hFFFF_FFF8) << 4) ^ t;
        end
        t = ((s << 3) ^ s) >> 11;
        return ((s & 32'hFFFF_FFF0) << 17) ^ t;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%f expected=%f", req, what, act, exp);
        end
    endtask

    task automatic step_model(output logic [23:0] a, output logic [23:0] b);
        logic [31:0] ra, rb;
        ra = 0;
        rb = 0;
        for (int c = 0; c < 3; c++) begin
            ga[c] = nxt(c, ga[c]);
            gb[c] = nxt(c, gb[c]);
            ra ^= ga[c];
            rb ^= gb[c];
        end
        a = ra[31:8];
        b = rb[31:8];
    endtask

    task automatic issue(input string tag);
        logic [23:0] a, b;
        step_model(a, b);
        q_u0.push_back(a);
        q_u1.push_back(b);
        q_cyc.push_back(cyc);
        q_tag.push_back(tag);
        in_enable = 1;
        @(negedge clk);
        in_enable = 0;
    endtask

    task automatic load_word(input bit gen, input int idx, input logic [31:0] v, input bit with_en);
        seed_load  = 1;
        seed_gen   = gen;
        seed_word  = 2'(idx);
        seed_value = v;
        in_enable  = with_en;
        @(negedge clk);
        seed_load = 0;
        in_enable = 0;
        if (idx < 3) begin
            if (gen) gb[idx] = legal(idx, v);
            else     ga[idx] = legal(idx, v);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && x1_valid) begin
            if (q_u0.size() == 0) begin
                extra++;
                chk(0, "R6 R9", "result without request", 1.0, 0.0);
            end else begin
                logic [23:0] a, b;
                int    ic;
                string tg;
                real   v1, v2, f, e1, e2, rad;
                a  = q_u0.pop_front();
                b  = q_u1.pop_front();
                ic = q_cyc.pop_front();
                tg = q_tag.pop_front();
                v1 = $itor($signed(x1)) / OSCALE;
                v2 = $itor($signed(x2)) / OSCALE;
                chk(x2_valid == 1'b1, "R6", "x2_valid with x1_valid", real'(x2_valid), 1.0);
                chk((cyc - ic) == LATENCY, "R6", "latency", real'(cyc - ic), real'(LATENCY));
                f   = $sqrt(-2.0 * $ln($itor((a == 0) ? 24'd1 : a) / USCALE));
                e1  = f * $sin(TWO_PI * $itor(b) / USCALE);
                e2  = f * $cos(TWO_PI * $itor(b) / USCALE);
                rad = $sqrt(v1 * v1 + v2 * v2);
                if (a == 0) begin
                    chk((rad - f < 0.03) && (f - rad < 0.03), {tg, " R5"}, "radius for zero code", rad, f);
                end else if (a < 24'h040000) begin
                    chk((rad > 2.8) && (rad < 5.85), {tg, " R4"}, "radius first segment", rad, f);
                end else begin
                    chk((v1 - e1 < 0.06) && (e1 - v1 < 0.06), {tg, " R4 x1"}, "value", v1, e1);
                    chk((v2 - e2 < 0.06) && (e2 - v2 < 0.06), {tg, " R4 x2"}, "value", v2, e2);
                end
                if (stats_on) begin
                    n_stat++;
                    s1 += v1; s2 += v2; q1 += v1 * v1; q2 += v2 * v2; c12 += v1 * v2;
                end
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 50 && q_u0.size() != 0; i++) @(negedge clk);
        chk(q_u0.size() == 0, "R6", "missing results", real'(q_u0.size()), 0.0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            ga[c] = legal(c, B_SEED_A[32*c +: 32]);
            gb[c] = legal(c, B_SEED_B[32*c +: 32]);
        end
        repeat (3) @(negedge clk);
        chk(x1_valid == 0, "R1", "x1_valid in reset", real'(x1_valid), 0.0);
        rst_n = 1;
        @(negedge clk);
        chk(x1_valid == 0 && x2_valid == 0, "R1", "valids after reset", real'(x1_valid), 0.0);
        chk(x1 == 0 && x2 == 0, "R1", "outputs after reset", real'(x1 | x2), 0.0);

        // Back-to-back from reset seeds (word1 of B is below floor: R8)
        for (int i = 0; i < 8; i++) issue("R1 R2 R3 R8");
        drain();

        // Gapped requests: generators must hold between them
        for (int i = 0; i < 8; i++) begin
            issue("R2 R3 gap");
            repeat (i % 3) @(negedge clk);
        end
        drain();

        // Load with enable high: no sample, no advance
        extra = 0;
        load_word(0, 1, 32'h6C07_8965, 1);
        load_word(1, 2, 32'h9E37_79B9, 1);
        load_word(1, 3, 32'h0000_0000, 1);
        repeat (LATENCY + 2) @(negedge clk);
        chk(extra == 0, "R9", "results from blocked cycles", real'(extra), 0.0);
        for (int i = 0; i < 6; i++) issue("R7 R9");
        drain();

        // Seeds below floor on generator B
        load_word(1, 0, 32'd0, 0);
        load_word(1, 1, 32'd5, 0);
        load_word(1, 2, 32'd3, 0);
        for (int i = 0; i < 8; i++) issue("R8");
        drain();

        // Solve a word0 for generator A so that the next u0 is zero
        begin
            logic [31:0] n1, n2, z, d;
            n1 = nxt(1, ga[1]);
            n2 = nxt(2, ga[2]);
            d  = (n1 ^ n2) >> 8;
            z  = 0;
            z[19:1]  = d[23:5];
            z[31:27] = d[4:0] ^ z[18:14];
            load_word(0, 0, z, 0);
            issue("R5");
            drain();
        end

        // Long run for distribution
        stats_on = 1;
        for (int i = 0; i < 4096; i++) issue("R10 run");
        drain();
        stats_on = 0;
        begin
            real n, m1, m2, va1, va2, r;
            n   = real'(n_stat);
            m1  = s1 / n;
            m2  = s2 / n;
            va1 = q1 / n - m1 * m1;
            va2 = q2 / n - m2 * m2;
            r   = (c12 / n - m1 * m2) / $sqrt(va1 * va2);
            chk(n_stat == 4096, "R10", "sample count", n, 4096.0);
            chk(m1 < 0.1 && m1 > -0.1, "R10", "x1 mean", m1, 0.0);
            chk(m2 < 0.1 && m2 > -0.1, "R10", "x2 mean", m2, 0.0);
            chk(va1 > 0.85 && va1 < 1.15, "R10", "x1 variance", va1, 1.0);
            chk(va2 > 0.85 && va2 < 1.15, "R10", "x2 variance", va2, 1.0);
            chk(r < 0.08 && r > -0.08, "R10", "correlation", r, 0.0);
        end
        finish_run();
    end

endmodule